// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block translates 32-bit virtual addresses to physical addresses through a small, fully associative table. Each table slot describes a pair of adjacent virtual pages and holds two frame descriptors: one for the even page and one for the odd page. Each descriptor has its own valid and dirty flags. A slot also carries a page-size code, an address-space tag and a global flag. A request gives an address, an address-space tag, an access kind (fetch, load or store), an access size and a privilege flag. In the same cycle the block returns a physical address, an uncacheable hint and a fault code. It also returns the values an exception handler needs to rebuild the failing translation.

Two fixed windows in the upper half of the address space bypass the table. The first window is open only to privileged code. Software fills the table through a write port that takes a slot index, and it clears the whole table with a flush input. A probe port takes a page number and an address-space tag and reports which slot answers them. The same logic serves the probe port and the lookup path, so a probe always agrees with a real lookup.

Top module: `pair_tlb`

## Requirements
- R1: A slot matches when it has been written since the last flush, when its page number equals the request page number on every bit that the slot's size code does not ignore, and when the slot is global or its tag equals the request tag. Size code c ignores the low 2*c page-number bits and gives pages of 1 KB << 2c. If several slots match, the lowest index is used.
- R2: The request page number is address bits 31..11. Its two low bits are forced to zero unless small pages are enabled (`small_pg_en` = 1).
- R3: Address bit 10+2c selects the half of a matching slot with size code c. A zero picks the even half's valid flag, dirty flag and frame. A one picks the odd half's.
- R4: Fault codes are 0 none, 1 address error on fetch/load, 2 address error on store, 3 fetch refill, 4 fetch invalid, 5 data refill, 6 data invalid, 7 modified. No match gives a refill fault (3 or 5). A match with a clear selected valid flag gives an invalid fault (4 or 6).
- R5: A store that hits a valid half with a clear dirty flag gives code 7 and no translation. A load in the same situation translates normally.
- R6: On a translation, `pa` is the selected frame number (1 KB units) shifted left by 10 with the low 10+2c bits cleared, ORed with the address bits below bit 10+2c. `pa` is zero whenever the fault code is non-zero.
- R7: With a non-zero fault code, the outputs carry the request tag, VPN2 (page number >> 2), the two low page-number bits, and the full faulting address. With no fault, all four are zero.
- R8: Addresses 0x80000000–0x9FFFFFFF and 0xA0000000–0xBFFFFFFF bypass the table and give `pa` = address & 0x1FFFFFFF. In the first window an access without the privilege flag gives code 1 or 2.
- R9: An access is misaligned when it is a halfword (size 1) with bit 0 set, or a word (size 2 or 3) with bits 1..0 non-zero. It gives code 2 for stores and code 1 otherwise, in any address region.
- R10: `uncached` is high exactly when address bits 31 and 29 are both set.
- R11: The probe returns the lowest matching slot index with `prb_hit` high, or all ones with `prb_hit` low. The probe page number is used unmodified.
- R12: A write whose index is not below the slot count changes no slot.
- R13: After reset or a flush, no slot matches until it is written again. Flush has priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties the table |
| flush | input | 1 | Empties the table at the next edge |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W+1 | Slot index to write |
| wr_vpn | input | 21 | Page-pair number of the new slot |
| wr_asid | input | ASID_W | Address-space tag of the new slot |
| wr_glob | input | 1 | Global flag, tag ignored when set |
| wr_pgsz | input | PGSZ_W | Page-size code |
| wr_pfn_even | input | 22 | Even-page frame, 1 KB units |
| wr_valid_even | input | 1 | Even-page valid flag |
| wr_dirty_even | input | 1 | Even-page writable flag |
| wr_pfn_odd | input | 22 | Odd-page frame, 1 KB units |
| wr_valid_odd | input | 1 | Odd-page valid flag |
| wr_dirty_odd | input | 1 | Odd-page writable flag |
| req_va | input | 32 | Request virtual address |
| req_asid | input | ASID_W | Request address-space tag |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store (3 acts as load) |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_kernel | input | 1 | Privileged access |
| small_pg_en | input | 1 | Keeps the two low page-number bits |
| pa | output | 32 | Physical address |
| uncached | output | 1 | Uncacheable hint |
| fault | output | 3 | Fault code |
| flt_asid | output | ASID_W | Faulting tag |
| flt_vpn2 | output | 19 | Faulting page number >> 2 |
| flt_vpn2x | output | 2 | Low two faulting page-number bits |
| flt_badva | output | 32 | Faulting virtual address |
| prb_vpn | input | 21 | Probe page number |
| prb_asid | input | ASID_W | Probe tag |
| prb_hit | output | 1 | Probe found a slot |
| prb_idx | output | IDX_W+1 | Probe slot index, all ones on miss |

## Verification
The lookup is exercised with four populated slots. Two of them overlap on the same page pair and tag, which separates lowest-index priority from the wrong order. The patterns cover:
- even and odd halves of 1 KB, 4 KB and 64 KB pages, which separate half selection and frame alignment per size code;
- store and load to a clean half, which separates the modified fault from a plain translation;
- fetch and data access to missing and invalid pages, which separates the four table fault codes;
- one address with and without small-page mode, which shows whether the low page-number bits are cleared.

Direct-window, privilege and misalignment patterns separate bypass from address errors. Probes that hit, probes under a size mask and probes that miss cover the probe port. An out-of-range write aimed at an index whose low bits name a live slot exposes any truncated decode.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

   localparam int VA_W    = 32;
   localparam int PG_LSB  = 11;              // page-pair number starts here
   localparam int VPN_W   = VA_W - PG_LSB;
   localparam int FRM_LSB = 10;              // frames counted in 1 KB units
   localparam int PFN_W   = VA_W - FRM_LSB;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ADDR_LD  = 3'd1,
      FLT_ADDR_ST  = 3'd2,
      FLT_I_REFILL = 3'd3,
      FLT_I_INVAL  = 3'd4,
      FLT_D_REFILL = 3'd5,
      FLT_D_INVAL  = 3'd6,
      FLT_MODIFY   = 3'd7
   } flt_e;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_e;

   // page-number bits a slot of size code 'code' does not compare
   function automatic logic [VPN_W-1:0] vpn_ign_mask(input int code);
      logic [VPN_W-1:0] m;
      for (int b = 0; b < VPN_W; b++) m[b] = (b < 2 * code);
      return m;
   endfunction

   // address bit choosing the even/odd half for size code 'code'
   function automatic logic [4:0] half_bit(input int code);
      return 5'(FRM_LSB + 2 * code);
   endfunction

endpackage

// File: rtl/pair_tlb_entry.sv
module pair_tlb_entry
   import pair_tlb_pkg::*;
#(
   parameter int ASID_W = 8,
   parameter int PGSZ_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              we,
   input  logic [VPN_W-1:0]  w_vpn,
   input  logic [ASID_W-1:0] w_asid,
   input  logic              w_glob,
   input  logic [PGSZ_W-1:0] w_pgsz,
   input  logic [PFN_W-1:0]  w_pfn_e,
   input  logic              w_v_e,
   input  logic              w_d_e,
   input  logic [PFN_W-1:0]  w_pfn_o,
   input  logic              w_v_o,
   input  logic              w_d_o,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VPN_W-1:0]  pb_vpn,
   input  logic [ASID_W-1:0] pb_asid,
   output logic              lk_hit,
   output logic              pb_hit,
   output logic              h_valid,
   output logic              h_dirty,
   output logic [PFN_W-1:0]  h_pfn,
   output logic [PGSZ_W-1:0] h_pgsz
);

   logic              live_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              glob_q;
   logic [PGSZ_W-1:0] pgsz_q;
   logic [PFN_W-1:0]  pfn_q [2];
   logic [1:0]        v_q;
   logic [1:0]        d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      live_q <= 1'b0;
      else if (flush)  live_q <= 1'b0;          // R13 flush beats write
      else if (we)     live_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we && !flush) begin
         vpn_q    <= w_vpn;
         asid_q   <= w_asid;
         glob_q   <= w_glob;
         pgsz_q   <= w_pgsz;
         pfn_q[0] <= w_pfn_e;
         pfn_q[1] <= w_pfn_o;
         v_q      <= {w_v_o, w_v_e};
         d_q      <= {w_d_o, w_d_e};
      end
   end

   logic [VPN_W-1:0] ign;
   logic [4:0]       hb;
   logic             odd;

   assign ign = vpn_ign_mask(int'(pgsz_q));
   assign hb  = half_bit(int'(pgsz_q));
   assign odd = lk_va[hb];

   assign lk_hit  = live_q && (((lk_vpn ^ vpn_q) & ~ign) == '0)
                    && (glob_q || (asid_q == lk_asid));
   assign pb_hit  = live_q && (((pb_vpn ^ vpn_q) & ~ign) == '0)
                    && (glob_q || (asid_q == pb_asid));
   assign h_valid = v_q[odd];
   assign h_dirty = d_q[odd];
   assign h_pfn   = pfn_q[odd];
   assign h_pgsz  = pgsz_q;

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!lk_hit && !pb_hit));                              // R13

   AST_WRITE_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we && !flush && rst_n) && pb_vpn == $past(w_vpn)
       && pb_asid == $past(w_asid)) |-> pb_hit);                    // R11

endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
   import pair_tlb_pkg::*;
#(
   parameter int ENTRIES        = 8,
   parameter int ASID_W         = 8,
   parameter int PGSZ_W         = 3,
   parameter bit SMALL_PAGES_OK = 1'b1,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int WIDX_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [20:0]       wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic [PGSZ_W-1:0] wr_pgsz,
   input  logic [21:0]       wr_pfn_even,
   input  logic              wr_valid_even,
   input  logic              wr_dirty_even,
   input  logic [21:0]       wr_pfn_odd,
   input  logic              wr_valid_odd,
   input  logic              wr_dirty_odd,
   input  logic [31:0]       req_va,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [1:0]        req_acc,
   input  logic [1:0]        req_size,
   input  logic              req_kernel,
   input  logic              small_pg_en,
   output logic [31:0]       pa,
   output logic              uncached,
   output logic [2:0]        fault,
   output logic [ASID_W-1:0] flt_asid,
   output logic [18:0]       flt_vpn2,
   output logic [1:0]        flt_vpn2x,
   output logic [31:0]       flt_badva,
   input  logic [20:0]       prb_vpn,
   input  logic [ASID_W-1:0] prb_asid,
   output logic              prb_hit,
   output logic [WIDX_W-1:0] prb_idx
);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("pair_tlb: ENTRIES must lie in 2..64");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("pair_tlb: ASID_W must lie in 1..16");
   end
   if (PGSZ_W < 1 || PGSZ_W > 3) begin : g_bad_pgsz
      $error("pair_tlb: PGSZ_W must lie in 1..3");
   end

   // ---------------- lookup page number (R2) ----------------
   logic [VPN_W-1:0] raw_vpn, lk_vpn;
   assign raw_vpn = req_va[VA_W-1:PG_LSB];

   if (SMALL_PAGES_OK) begin : g_small
      assign lk_vpn = small_pg_en ? raw_vpn : {raw_vpn[VPN_W-1:2], 2'b00};
   end else begin : g_large_only
      logic unused_sp;
      assign unused_sp = small_pg_en;
      assign lk_vpn    = {raw_vpn[VPN_W-1:2], 2'b00};
   end

   // ---------------- slot array ----------------
   logic [ENTRIES-1:0] lk_hit, pb_hit, hv, hd;
   logic [PFN_W-1:0]   hp [ENTRIES];
   logic [PGSZ_W-1:0]  hz [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      pair_tlb_entry #(.ASID_W(ASID_W), .PGSZ_W(PGSZ_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .we      (wr_en && (wr_idx == WIDX_W'(i))),   // R12 full-width compare
         .w_vpn   (wr_vpn),
         .w_asid  (wr_asid),
         .w_glob  (wr_glob),
         .w_pgsz  (wr_pgsz),
         .w_pfn_e (wr_pfn_even),
         .w_v_e   (wr_valid_even),
         .w_d_e   (wr_dirty_even),
         .w_pfn_o (wr_pfn_odd),
         .w_v_o   (wr_valid_odd),
         .w_d_o   (wr_dirty_odd),
         .lk_va   (req_va),
         .lk_vpn  (lk_vpn),
         .lk_asid (req_asid),
         .pb_vpn  (prb_vpn),
         .pb_asid (prb_asid),
         .lk_hit  (lk_hit[i]),
         .pb_hit  (pb_hit[i]),
         .h_valid (hv[i]),
         .h_dirty (hd[i]),
         .h_pfn   (hp[i]),
         .h_pgsz  (hz[i])
      );
   end

   logic             lk_any, pb_any;
   logic [IDX_W-1:0] lk_idx, pb_idx;

   pair_tlb_pick #(.N(ENTRIES)) u_lk_pick (.req(lk_hit), .any(lk_any), .idx(lk_idx));
   pair_tlb_pick #(.N(ENTRIES)) u_pb_pick (.req(pb_hit), .any(pb_any), .idx(pb_idx));

   // ---------------- probe (R11) ----------------
   assign prb_hit = pb_any;
   assign prb_idx = pb_any ? {1'b0, pb_idx} : '1;

   // ---------------- translation ----------------
   logic             sel_v, sel_d;
   logic [PFN_W-1:0] sel_pfn;
   logic [4:0]       sh;
   logic [VA_W-1:0]  off_m, map_pa;
   logic             in_k0, in_k1, misal, is_st, is_fe;
   flt_e             flt;

   assign sel_v   = hv[lk_idx];
   assign sel_d   = hd[lk_idx];
   assign sel_pfn = hp[lk_idx];
   assign sh      = half_bit(int'(hz[lk_idx]));
   assign off_m   = (32'h1 << sh) - 32'h1;
   assign map_pa  = ({sel_pfn, 10'b0} & ~off_m) | (req_va & off_m);   // R6

   assign in_k0    = (req_va[31:29] == 3'b100);
   assign in_k1    = (req_va[31:29] == 3'b101);
   assign misal    = (req_size == 2'd1 && req_va[0])
                     || (req_size[1] && req_va[1:0] != 2'b00);        // R9
   assign is_st    = (req_acc == ACC_STORE);
   assign is_fe    = (req_acc == ACC_FETCH);
   assign uncached = ((req_va & 32'hA000_0000) == 32'hA000_0000);     // R10

   always_comb begin
      flt = FLT_NONE;
      pa  = '0;
      if (misal || (in_k0 && !req_kernel))
         flt = is_st ? FLT_ADDR_ST : FLT_ADDR_LD;                      // R8 R9
      else if (in_k0 || in_k1)
         pa = req_va & 32'h1FFF_FFFF;                                  // R8
      else if (!lk_any)
         flt = is_fe ? FLT_I_REFILL : FLT_D_REFILL;                    // R4
      else if (!sel_v)
         flt = is_fe ? FLT_I_INVAL : FLT_D_INVAL;                      // R4
      else if (is_st && !sel_d)
         flt = FLT_MODIFY;                                             // R5
      else
         pa = map_pa;
   end

   assign fault = flt;

   // ---------------- handler information (R7) ----------------
   always_comb begin
      flt_asid  = '0;
      flt_vpn2  = '0;
      flt_vpn2x = '0;
      flt_badva = '0;
      if (flt != FLT_NONE) begin
         flt_asid  = req_asid;
         flt_vpn2  = lk_vpn[VPN_W-1:2];
         flt_vpn2x = lk_vpn[1:0];
         flt_badva = req_va;
      end
   end

   // ---------------- assertions ----------------
   AST_PROBE_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !prb_hit |-> (&prb_idx));                                         // R11

   AST_WINDOW_NO_TABLE_FLT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_va[31:30] == 2'b10) |-> (fault inside {3'd0, 3'd1, 3'd2}));  // R8

   AST_LOAD_NEVER_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_acc == 2'd1) |-> (fault != 3'd7));                           // R5

   AST_MISALIGN_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size == 2'd2 && req_va[1:0] != 2'b00) |-> (fault inside {3'd1, 3'd2})); // R9

   AST_QUIET_INFO: assert property (@(posedge clk) disable iff (!rst_n)
      (fault == 3'd0) |-> (flt_badva == '0 && flt_asid == '0));         // R7

   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 3'd0) |-> (pa == '0));                                  // R6

endmodule

// File: tb/test_pair_tlb.sv
module test_pair_tlb;

   localparam int ENTRIES = 8;
   localparam int ASID_W  = 8;
   localparam int PGSZ_W  = 3;
   localparam int WIDX_W  = $clog2(ENTRIES) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              wr_en = 1'b0;
   logic [WIDX_W-1:0] wr_idx = '0;
   logic [20:0]       wr_vpn = '0;
   logic [ASID_W-1:0] wr_asid = '0;
   logic              wr_glob = 1'b0;
   logic [PGSZ_W-1:0] wr_pgsz = '0;
   logic [21:0]       wr_pfn_even = '0, wr_pfn_odd = '0;
   logic              wr_valid_even = 1'b0, wr_dirty_even = 1'b0;
   logic              wr_valid_odd = 1'b0, wr_dirty_odd = 1'b0;
   logic [31:0]       req_va = '0;
   logic [ASID_W-1:0] req_asid = '0;
   logic [1:0]        req_acc = 2'd1, req_size = 2'd2;
   logic              req_kernel = 1'b0, small_pg_en = 1'b0;
   logic [31:0]       pa, flt_badva;
   logic              uncached, prb_hit;
   logic [2:0]        fault;
   logic [ASID_W-1:0] flt_asid;
   logic [18:0]       flt_vpn2;
   logic [1:0]        flt_vpn2x;
   logic [20:0]       prb_vpn = '0;
   logic [ASID_W-1:0] prb_asid = '0;
   logic [WIDX_W-1:0] prb_idx;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pair_tlb #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .PGSZ_W(PGSZ_W)) i_pair_tlb (
      .clk, .rst_n, .flush, .wr_en, .wr_idx, .wr_vpn, .wr_asid, .wr_glob, .wr_pgsz,
      .wr_pfn_even, .wr_valid_even, .wr_dirty_even,
      .wr_pfn_odd, .wr_valid_odd, .wr_dirty_odd,
      .req_va, .req_asid, .req_acc, .req_size, .req_kernel, .small_pg_en,
      .pa, .uncached, .fault, .flt_asid, .flt_vpn2, .flt_vpn2x, .flt_badva,
      .prb_vpn, .prb_asid, .prb_hit, .prb_idx
   );

   typedef struct packed {
      logic [31:0] va;
      logic [7:0]  asid;
      logic [1:0]  acc;
      logic [1:0]  sz;
      logic        kern;
      logic        sp;
      logic [2:0]  flt;
      logic [31:0] pa;
      logic        uc;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 22;
   // acc: 0 fetch, 1 load, 2 store; sz: 0 byte, 1 half, 2 word
   localparam vec_t VECS [0:NV-1] = '{
      '{32'h0000_8124, 8'd5, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0004_0124, 1'b0, 8'd1},  // R1 lowest index
      '{32'h0000_9124, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0, 3'd7, 32'h0,         1'b0, 8'd5},  // R5 store clean
      '{32'h0000_9124, 8'd5, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0008_0124, 1'b0, 8'd3},  // R3 odd half
      '{32'h0000_8124, 8'd6, 2'd0, 2'd2, 1'b0, 1'b0, 3'd3, 32'h0,         1'b0, 8'd4},  // R4 fetch refill
      '{32'h0000_8124, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0004_0124, 1'b0, 8'd5},  // R5 store dirty
      '{32'h0002_0010, 8'd9, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 32'h000C_CC10, 1'b0, 8'd1},  // R1 global
      '{32'h0002_0410, 8'd9, 2'd0, 2'd2, 1'b0, 1'b0, 3'd4, 32'h0,         1'b0, 8'd4},  // R4 fetch invalid
      '{32'h0002_0410, 8'd9, 2'd1, 2'd2, 1'b0, 1'b0, 3'd6, 32'h0,         1'b0, 8'd4},  // R4 data invalid
      '{32'h0002_1010, 8'd9, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 32'h000C_CC10, 1'b0, 8'd2},  // R2 bits cleared
      '{32'h0002_1010, 8'd9, 2'd1, 2'd2, 1'b0, 1'b1, 3'd5, 32'h0,         1'b0, 8'd2},  // R2 bits kept
      '{32'h4000_ABCC, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0123_ABCC, 1'b0, 8'd6},  // R6 64 KB even
      '{32'h4001_0008, 8'd5, 2'd1, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0124_0008, 1'b0, 8'd3},  // R3 64 KB odd
      '{32'h8000_1234, 8'd0, 2'd1, 2'd2, 1'b1, 1'b0, 3'd0, 32'h0000_1234, 1'b0, 8'd8},  // R8 window 0
      '{32'h8000_1234, 8'd0, 2'd1, 2'd2, 1'b0, 1'b0, 3'd1, 32'h0,         1'b0, 8'd8},  // R8 user in window 0
      '{32'hA000_1234, 8'd0, 2'd2, 2'd2, 1'b0, 1'b0, 3'd0, 32'h0000_1234, 1'b1, 8'd10}, // R10 window 1
      '{32'hA000_1234, 8'd0, 2'd0, 2'd2, 1'b1, 1'b0, 3'd0, 32'h0000_1234, 1'b1, 8'd10}, // R10
      '{32'h0000_8126, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0, 3'd2, 32'h0,         1'b0, 8'd9},  // R9 store word
      '{32'h0000_8126, 8'd5, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 32'h0004_0126, 1'b0, 8'd9},  // R9 half ok
      '{32'h0000_8127, 8'd5, 2'd1, 2'd0, 1'b0, 1'b0, 3'd0, 32'h0004_0127, 1'b0, 8'd9},  // R9 byte ok
      '{32'h0000_8002, 8'd5, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 32'h0,         1'b0, 8'd9},  // R9 fetch word
      '{32'hE000_0000, 8'd5, 2'd1, 2'd2, 1'b1, 1'b0, 3'd5, 32'h0,         1'b1, 8'd10}, // R10 mapped miss
      '{32'h8000_1236, 8'd0, 2'd2, 2'd2, 1'b1, 1'b0, 3'd2, 32'h0,         1'b0, 8'd9}   // R9 in window
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [WIDX_W-1:0] idx, input logic [20:0] vpn,
                     input logic [7:0] asid, input logic g, input logic [2:0] psz,
                     input logic [21:0] pe, input logic ve, input logic de,
                     input logic [21:0] po, input logic vo, input logic dx);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_glob = g;
      wr_pgsz = psz; wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
      wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dx;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, input logic [7:0] asid,
                       input logic [1:0] acc, input logic [1:0] sz,
                       input logic kern, input logic sp);
      @(negedge clk);
      req_va = va; req_asid = asid; req_acc = acc; req_size = sz;
      req_kernel = kern; small_pg_en = sp;
      #2;
   endtask

   task automatic probe(input logic [20:0] vpn, input logic [7:0] asid);
      @(negedge clk);
      prb_vpn = vpn; prb_asid = asid;
      #2;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state: empty table
      look(32'h0000_8124, 8'd5, 2'd1, 2'd2, 1'b0, 1'b0);
      chk("R13 reset lookup fault", 32'(fault), 32'd5);
      probe(21'h10, 8'd5);
      chk("R13 reset probe hit", 32'(prb_hit), 32'd0);
      chk("R11 reset probe idx", 32'(prb_idx), 32'hF);

      wr(4'd0, 21'h00010, 8'd5, 1'b0, 3'd1, 22'h00100, 1'b1, 1'b1, 22'h00200, 1'b1, 1'b0);
      wr(4'd1, 21'h00040, 8'd0, 1'b1, 3'd0, 22'h00333, 1'b1, 1'b1, 22'h00444, 1'b0, 1'b0);
      wr(4'd2, 21'h80000, 8'd5, 1'b0, 3'd3, 22'h048FF, 1'b1, 1'b1, 22'h04900, 1'b1, 1'b1);
      wr(4'd3, 21'h00010, 8'd5, 1'b0, 3'd1, 22'h00555, 1'b1, 1'b1, 22'h00666, 1'b1, 1'b1);

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         v = VECS[k];
         look(v.va, v.asid, v.acc, v.sz, v.kern, v.sp);
         chk($sformatf("R%0d vec%0d fault", v.rq, k), 32'(fault), 32'(v.flt));
         chk($sformatf("R%0d vec%0d pa", v.rq, k), pa, v.pa);
         chk($sformatf("R%0d vec%0d uncached", v.rq, k), 32'(uncached), 32'(v.uc));
      end

      // R7 handler information
      look(32'h0000_9124, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0);
      chk("R7 asid", 32'(flt_asid), 32'd5);
      chk("R7 vpn2", 32'(flt_vpn2), 32'h4);
      chk("R7 vpn2x", 32'(flt_vpn2x), 32'd0);
      chk("R7 badva", flt_badva, 32'h0000_9124);
      look(32'h0002_1810, 8'd2, 2'd1, 2'd2, 1'b0, 1'b1);
      chk("R2 small-page miss", 32'(fault), 32'd5);
      chk("R7 vpn2 small", 32'(flt_vpn2), 32'h10);
      chk("R7 vpn2x small", 32'(flt_vpn2x), 32'd3);
      chk("R7 asid small", 32'(flt_asid), 32'd2);
      look(32'h0000_8124, 8'd5, 2'd1, 2'd2, 1'b0, 1'b0);
      chk("R7 quiet badva", flt_badva, 32'h0);
      chk("R7 quiet vpn2", 32'(flt_vpn2), 32'h0);

      // R11 probe
      probe(21'h10, 8'd5);
      chk("R11 probe lowest", 32'(prb_idx), 32'd0);
      probe(21'h13, 8'd5);
      chk("R11 probe masked", 32'(prb_idx), 32'd0);
      probe(21'h40, 8'd77);
      chk("R11 probe global", 32'(prb_idx), 32'd1);
      probe(21'h10, 8'd6);
      chk("R11 probe tag miss", 32'(prb_idx), 32'hF);
      chk("R11 probe hit low", 32'(prb_hit), 32'd0);

      // R12 out-of-range write: index 9 aliases slot 1 in its low bits
      wr(4'd9, 21'h00099, 8'd5, 1'b0, 3'd0, 22'h00777, 1'b1, 1'b1, 22'h00777, 1'b1, 1'b1);
      look(32'h0002_0010, 8'd9, 2'd1, 2'd2, 1'b0, 1'b0);
      chk("R12 slot1 intact", pa, 32'h000C_CC10);
      probe(21'h99, 8'd5);
      chk("R12 no new slot", 32'(prb_hit), 32'd0);

      // R13 flush
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      look(32'h4000_ABCC, 8'd5, 2'd2, 2'd2, 1'b0, 1'b0);
      chk("R13 flushed lookup", 32'(fault), 32'd5);
      probe(21'h40, 8'd0);
      chk("R13 flushed probe", 32'(prb_hit), 32'd0);

      finish_run();
   end

endmodule